// File: doc/BRIEF.md
# Peripheral Interrupt and Soft-Reset Unit

This unit sits beside a serial-peripheral master core on the same 32-bit register bus. The core delivers seven kinds of single-cycle event pulses to it. The unit latches each pulse into a sticky status bit. Each status bit passes through its own enable bit, and a global enable gates the combined result. The outcome is one registered, level-sensitive interrupt line.

Software clears status bits by writing ones to the status register. This lets a handler write back the value it just read and acknowledge exactly the events it saw. The unit also contains a keyed reset register. Writing the correct key starts a fixed-length soft reset for the core. During that window the unit clears its own status bits. The enable settings survive the soft reset.

Top module: `periph_irq_ctrl`

## Requirements
- R1: After the synchronous reset `rst_i`, every register reads 0, `irq_o` is low and `core_srst_o` is low.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit k at offset 0x20, and the bit stays set until it is cleared. The bit meanings are: bit0 mode fault, bit1 slave-select fault, bit2 transmit FIFO drained after shifting, bit3 transmit underrun, bit4 receive FIFO full, bit5 receive overrun, bit6 transmit FIFO half empty.
- R3: A write to offset 0x20 clears exactly the status bits written as 1. Bits written as 0 keep their value.
- R4: When an event pulse and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R5: `irq_o` is high exactly when, in the previous cycle, bit 31 of the global enable register at offset 0x1C was 1 and at least one status bit was set together with its enable bit at offset 0x28 (enable bit k gates status bit k).
- R6: Writing 0 to the enable register at 0x28 holds `irq_o` low, and the status bits remain readable and unchanged.
- R7: A write of 0x0000000A to offset 0x40 drives `core_srst_o` high for exactly 16 cycles, starting in the cycle after the write.
- R8: A write of any other value to offset 0x40 leaves `core_srst_o` low and the status bits unchanged.
- R9: While `core_srst_o` is high, the status bits are held at 0 and event pulses are ignored. The enable register and the global enable keep their values.
- R10: Read data appears on `bus_rdata_o` in the cycle after `bus_rd_i`. The reset register and all unassigned offsets read 0. Only bit 31 of 0x1C and bits 6:0 of 0x20 and 0x28 can read as 1.
- R11: A key write that arrives while `core_srst_o` is high is ignored and does not extend the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| evt_i | input | 7 | Single-cycle event pulses from the core |
| irq_o | output | 1 | Registered interrupt level |
| core_srst_o | output | 1 | Soft reset for the core |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. One is an event pulse landing in the very cycle that a write-one clear targets the same bit. The other is a second key write landing inside an active soft-reset window. The bench reaches both by driving the event lines and the bus strobes on the same falling edge, so the design sees them at one rising edge. For the window, it counts the high cycles of `core_srst_o` while it injects a second key write and an event pulse part-way through. The status and enable values are then read back through the bus to confirm what survived.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // register offsets, decoded by software
  localparam int OFF_GIE  = 'h1C;
  localparam int OFF_STAT = 'h20;
  localparam int OFF_IEN  = 'h28;
  localparam int OFF_SRST = 'h40;
  // key that triggers a soft reset of the core
  localparam logic [31:0] SRST_KEY = 32'h0000_000A;

  // event bit positions
  typedef enum int {
    EV_MODE_FAULT  = 0,
    EV_SLV_FAULT   = 1,
    EV_TX_DRAINED  = 2,
    EV_TX_UNDER    = 3,
    EV_RX_FULL     = 4,
    EV_RX_OVER     = 5,
    EV_TX_HALF     = 6
  } ev_pos_e;
endpackage

// File: rtl/pirq_status_bank.sv
module pirq_status_bank #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               srst_i,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] st_o
);
  logic [NUM_SRC-1:0] st_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (rst_i || srst_i)  st_q[k] <= 1'b0;
      else if (ev_i[k])     st_q[k] <= 1'b1;
      else if (clr_i[k])    st_q[k] <= 1'b0;
    end

    // R2 R4
    set_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (ev_i[k] && !srst_i) |=> st_q[k]);
    // R3
    clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr_i[k] && !ev_i[k]) |=> !st_q[k]);
    // R2
    sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!ev_i[k] && !clr_i[k] && !srst_i) |=> $stable(st_q[k]));
    // R9
    srst_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      srst_i |=> !st_q[k]);
  end

  assign st_o = st_q;
endmodule

// File: rtl/pirq_reset_seq.sv
module pirq_reset_seq #(
  parameter int SRST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic key_wr_i,
  input  logic other_wr_i,
  output logic srst_o
);
  localparam int CNT_W = $clog2(SRST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             srst_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      srst_q <= 1'b0;
    end else if (!srst_q) begin
      if (key_wr_i) begin
        cnt_q  <= CNT_W'(SRST_CYCLES - 1);
        srst_q <= 1'b1;
      end
    end else if (cnt_q == '0) begin
      srst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign srst_o = srst_q;

  // observation counter for the window length check
  logic [CNT_W:0] hi_run_q;
  always_ff @(posedge clk_i) begin
    if (rst_i)       hi_run_q <= '0;
    else if (srst_q) hi_run_q <= hi_run_q + 1'b1;
    else             hi_run_q <= '0;
  end

  // R7
  key_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (key_wr_i && !srst_q) |=> srst_q);
  // R7 R11
  window_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(srst_q) |-> (hi_run_q == (CNT_W+1)'(SRST_CYCLES)));
  // R8
  bad_key_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (other_wr_i && !srst_q) |=> !srst_q);
endmodule

// File: rtl/pirq_irq_gen.sv
module pirq_irq_gen #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               gie_i,
  input  logic [NUM_SRC-1:0] st_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= 1'b0;
    else       irq_q <= gie_i && (|(st_i & en_i));
  end

  assign irq_o = irq_q;

  // R5
  gie_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !gie_i |=> !irq_q);
  // R6
  mask_all_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i == '0) |=> !irq_q);
  // R5
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_q) |-> $past(st_i != '0));
endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_SRC     = 7,
  parameter int SRST_CYCLES = 16
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_o,
  output logic               core_srst_o
);
  localparam int GIE_BIT = DATA_W - 1;

  logic               sel_gie, sel_stat, sel_ien, sel_srst;
  logic               gie_q;
  logic [NUM_SRC-1:0] ien_q;
  logic [NUM_SRC-1:0] st;
  logic [NUM_SRC-1:0] clr;
  logic               key_wr, other_wr;
  logic               srst;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rdata_q;

  assign sel_gie  = (bus_addr_i == ADDR_W'(OFF_GIE));
  assign sel_stat = (bus_addr_i == ADDR_W'(OFF_STAT));
  assign sel_ien  = (bus_addr_i == ADDR_W'(OFF_IEN));
  assign sel_srst = (bus_addr_i == ADDR_W'(OFF_SRST));

  assign clr      = (bus_wr_i && sel_stat) ? bus_wdata_i[NUM_SRC-1:0] : '0;
  assign key_wr   = bus_wr_i && sel_srst && (bus_wdata_i == DATA_W'(SRST_KEY));
  assign other_wr = bus_wr_i && sel_srst && (bus_wdata_i != DATA_W'(SRST_KEY));

  // enable registers: untouched by the soft reset
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gie_q <= 1'b0;
      ien_q <= '0;
    end else if (bus_wr_i) begin
      if (sel_gie) gie_q <= bus_wdata_i[GIE_BIT];
      if (sel_ien) ien_q <= bus_wdata_i[NUM_SRC-1:0];
    end
  end

  pirq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .srst_i (srst),
    .ev_i   (evt_i),
    .clr_i  (clr),
    .st_o   (st)
  );

  pirq_reset_seq #(.SRST_CYCLES(SRST_CYCLES)) u_rstseq (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .key_wr_i   (key_wr),
    .other_wr_i (other_wr),
    .srst_o     (srst)
  );

  pirq_irq_gen #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .gie_i (gie_q),
    .st_i  (st),
    .en_i  (ien_q),
    .irq_o (irq_o)
  );

  // readback
  always_comb begin
    rd_mux = '0;
    if (sel_gie)       rd_mux[GIE_BIT]     = gie_q;
    else if (sel_stat) rd_mux[NUM_SRC-1:0] = st;
    else if (sel_ien)  rd_mux[NUM_SRC-1:0] = ien_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)         rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign core_srst_o = srst;

  // R9
  enables_kept_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (srst && !bus_wr_i) |=> ($stable(ien_q) && $stable(gie_q)));
  // R10
  rd_unmapped_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_rd_i && !sel_gie && !sel_stat && !sel_ien) |=> (bus_rdata_o == '0));
endmodule

// File: tb/periph_irq_ctrl_tb_top.sv
module periph_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr, rd;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [6:0]  evt;
  logic        irq, srst;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  periph_irq_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .evt_i(evt), .irq_o(irq), .core_srst_o(srst)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 8'h00; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0; addr = 8'h00;
    d = rdata;
  endtask

  task automatic pulse(input logic [6:0] m);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1; idle(3); rst = 1'b0; idle(1);
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    do_reset();
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 srst", {31'b0, srst}, 0);
    bus_read(8'h20, d); chk("R1 stat", d, 0);
    bus_read(8'h28, d); chk("R1 ien", d, 0);
    bus_read(8'h1C, d); chk("R1 gie", d, 0);
  endtask

  task automatic t_set_clear;
    logic [31:0] d;
    do_reset();
    pulse(7'h25);
    idle(3);
    bus_read(8'h20, d); chk("R2 sticky set", d, 32'h25);
    pulse(7'h40);
    bus_read(8'h20, d); chk("R2 half-empty bit6", d, 32'h65);
    bus_write(8'h20, 32'h0000_0005);
    bus_read(8'h20, d); chk("R3 w1c exact", d, 32'h60);
    bus_write(8'h20, 32'h0000_0060);
    bus_read(8'h20, d); chk("R3 clear rest", d, 0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    do_reset();
    pulse(7'h02);
    evt = 7'h02; wr = 1'b1; addr = 8'h20; wdata = 32'h0000_0003;
    @(negedge clk);
    evt = '0; wr = 1'b0; addr = 8'h00; wdata = '0;
    bus_read(8'h20, d); chk("R4 event beats clear", d, 32'h02);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    do_reset();
    bus_write(8'h28, 32'h0000_0010);
    pulse(7'h08);
    idle(1);
    chk("R5 disabled source", {31'b0, irq}, 0);
    pulse(7'h10);
    idle(1);
    chk("R5 no gie", {31'b0, irq}, 0);
    bus_write(8'h1C, 32'h8000_0000);
    chk("R5 latency low", {31'b0, irq}, 0);
    idle(1);
    chk("R5 irq high", {31'b0, irq}, 1);
    bus_write(8'h20, 32'h0000_0010);
    idle(1);
    chk("R5 cleared drops", {31'b0, irq}, 0);
    pulse(7'h01);
    bus_write(8'h28, 32'h0000_0001);
    idle(1);
    chk("R5 mode fault", {31'b0, irq}, 1);
    bus_write(8'h28, 32'h0000_0000);
    idle(1);
    chk("R6 mask all", {31'b0, irq}, 0);
    bus_read(8'h20, d); chk("R6 status kept", d, 32'h09);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    do_reset();
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_read(8'h1C, d); chk("R10 gie bit31 only", d, 32'h8000_0000);
    bus_read(8'h28, d); chk("R10 ien 7 bits", d, 32'h7F);
    bus_read(8'h40, d); chk("R10 reset reg reads 0", d, 0);
    bus_read(8'h04, d); chk("R10 unmapped 0", d, 0);
  endtask

  task automatic t_soft_reset;
    logic [31:0] d;
    int hi;
    do_reset();
    bus_write(8'h28, 32'h0000_0055);
    bus_write(8'h1C, 32'h8000_0000);
    pulse(7'h11);
    bus_write(8'h40, 32'h0000_000B);
    chk("R8 wrong key", {31'b0, srst}, 0);
    idle(2);
    chk("R8 no srst", {31'b0, srst}, 0);
    bus_read(8'h20, d); chk("R8 status kept", d, 32'h11);
    bus_write(8'h40, 32'h0000_000A);
    chk("R7 starts", {31'b0, srst}, 1);
    hi = 1;
    for (int i = 0; i < 24; i++) begin
      if (i == 3) evt = 7'h7F;
      if (i == 6) begin wr = 1'b1; addr = 8'h40; wdata = 32'h0000_000A; end
      @(negedge clk);
      evt = '0; wr = 1'b0; addr = 8'h00; wdata = '0;
      if (srst) hi++;
    end
    chk("R7 R11 window 16", hi, 16);
    bus_read(8'h20, d); chk("R9 status cleared", d, 0);
    bus_read(8'h28, d); chk("R9 ien kept", d, 32'h55);
    bus_read(8'h1C, d); chk("R9 gie kept", d, 32'h8000_0000);
    chk("R9 irq low", {31'b0, irq}, 0);
  endtask

  initial begin
    rst = 1'b1; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; evt = '0;
    @(negedge clk);
    t_reset_state();
    t_set_clear();
    t_collision();
    t_irq();
    t_readback();
    t_soft_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule